// File: doc/BRIEF.md
# ADC configuration register and sequencer

This block holds the 8-bit setup byte of a four-input converter and runs the control logic that the byte governs. A host writes or reads the whole byte in one access over a plain strobe-based bus. The upper four bits select the analog inputs to convert. Each accepted conversion start takes the next selected input in rising index order and wraps back to the lowest selected input after the highest one.

A single shared status pin can be silent, show conversion activity, or show a latched alert. Its active level is set by one configuration bit. Alert events from the external limit logic set a sticky status bit for the channel converted last. A special code in the pin-role field clears all alert state, and that code is never stored as written. The line-filter bit is exported as a control output. The analog conversion itself appears only as a start/done handshake.

Top module: `adc_cfg_seq`

## Requirements
- R1: After reset the stored byte is 0x00, `bus_rdata` is 0x00, `conv_busy` is 0, `conv_chan` is 3 (so the first conversion takes the lowest selected input), `alert_status` is 0, `filt_en` is 0 and `stat_pin` is 1 (inactive, active-low).
- R2: A write stores `bus_wdata` one cycle after `bus_wr`. A read strobe loads the stored byte into `bus_rdata` one cycle later. Field layout: bits 7:4 enable inputs 3..0 (bit 4 is input 0), bit 3 is filter enable, bit 2 is alert enable, bit 1 is busy/alert select, bit 0 is pin polarity.
- R3: `filt_en` equals stored bit 3.
- R4: A start with a nonzero channel field while idle sets `conv_busy` next cycle. `conv_chan` becomes the lowest selected input above the previous `conv_chan`.
- R5: When no selected input lies above the previous one, the sequence wraps to the lowest selected input.
- R6: A start while bits 7:4 are all zero is ignored, and `conv_busy` stays 0.
- R7: While busy, starts are ignored and `conv_chan` holds. A `conv_done` strobe clears `conv_busy` on the next cycle.
- R8: With bits 2:1 = 01 the pin shows `conv_busy`: it sits at the active level while busy.
- R9: When bit 2 is 1, `alert_evt` sets `alert_status[conv_chan]`, and status bits stay set until cleared. With bits 2:1 = 10 the pin is active whenever any status bit is set.
- R10: With bits 2:1 = 00 the pin sits at its inactive level, the inverse of bit 0, whatever the busy or alert state. In every role bit 0 = 1 means active high and bit 0 = 0 means active low.
- R11: Writing 11 into bits 2:1 clears all status bits and the alert pin one cycle later. The byte is stored with bits 2:1 = 10, and a read returns that value.
- R12: `alert_evt` is ignored while bit 2 is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_wr | input | 1 | Single-byte write strobe |
| bus_rd | input | 1 | Single-byte read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid the cycle after `bus_rd` |
| conv_start | input | 1 | Request to begin a conversion |
| conv_done | input | 1 | Conversion finished strobe |
| alert_evt | input | 1 | Limit-violation event from the comparator |
| conv_busy | output | 1 | Conversion in progress |
| conv_chan | output | 2 | Input index of the current or last conversion |
| alert_status | output | 4 | Sticky per-input alert flags |
| filt_en | output | 1 | Serial-line filter enable |
| stat_pin | output | 1 | Shared busy/alert status pin |

## Verification
The hardest state to reach is a wrap of the sequencer right after the channel mask has changed mid-conversion. The new mask must be judged against a previous channel chosen under the old one. A second hard case is a clear code written in the same cycle as an alert event. The random phase writes fresh bytes often, including the clear code, while starts, done strobes and alert events arrive at independent rates. The bench model then has to predict every next channel and every status bit over thousands of such overlaps. Directed sequences first pin down the plain two-input wrap, the ignored start during busy, the readback after a clear, and the silent pin at both polarities.

// File: rtl/adc_cfg_pkg.sv
package adc_cfg_pkg;
  localparam int unsigned NUM_CH = 4;
  localparam int unsigned CH_W   = $clog2(NUM_CH);
  localparam int unsigned CFG_W  = NUM_CH + 4;

  typedef struct packed {
    logic [NUM_CH-1:0] chan_en;
    logic              filt_on;
    logic              alert_on;
    logic              role_sel;
    logic              pol_hi;
  } cfg_t;

  typedef enum logic [1:0] {
    PIN_OFF   = 2'b00,
    PIN_BUSY  = 2'b01,
    PIN_ALERT = 2'b10,
    PIN_CLEAR = 2'b11
  } pin_mode_e;
endpackage

// File: rtl/adc_cfg_rst_sync.sv
module adc_cfg_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_async,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_async) begin
    if (!rst_n_async) sync_q <= '0;
    else              sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = sync_q[STAGES-1];
endmodule

// File: rtl/adc_cfg_reg.sv
module adc_cfg_reg
  import adc_cfg_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             rd_en,
  input  logic [CFG_W-1:0] wdata,
  output cfg_t             cfg_o,
  output logic [CFG_W-1:0] rdata_o,
  output logic             clr_o
);
  cfg_t             cfg_q, cfg_d;
  logic [CFG_W-1:0] rd_q, rd_d;
  pin_mode_e        wmode;

  // next state
  always_comb begin
    wmode = pin_mode_e'(wdata[2:1]);
    clr_o = wr_en && (wmode == PIN_CLEAR);
    cfg_d = cfg_t'(wdata);
    if (clr_o) begin
      // clear code is consumed: the field settles on alert role
      cfg_d.alert_on = 1'b1;
      cfg_d.role_sel = 1'b0;
    end
    rd_d = cfg_q;
  end

  // registers with explicit enables
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
      rd_q  <= '0;
    end else begin
      if (wr_en) cfg_q <= cfg_d;
      if (rd_en) rd_q  <= rd_d;
    end
  end

  assign cfg_o   = cfg_q;
  assign rdata_o = rd_q;

  assert_write_store_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wdata[2:1] != 2'b11) |=> (cfg_q == $past(wdata)));

  assert_read_back_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> (rdata_o == $past(cfg_o)));

  assert_clear_code_not_kept_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wdata[2:1] == 2'b11) |=> (cfg_q[2:1] == 2'b10 && cfg_q[7:3] == $past(wdata[7:3])));
endmodule

// File: rtl/adc_cfg_chan_seq.sv
module adc_cfg_chan_seq
  import adc_cfg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              done_i,
  input  logic [NUM_CH-1:0] mask_i,
  output logic              busy_o,
  output logic [CH_W-1:0]   chan_o
);
  logic              busy_q, busy_d;
  logic [CH_W-1:0]   chan_q, chan_d;
  logic [NUM_CH-1:0] above;
  logic              any_above;
  logic              take;
  logic [CH_W-1:0]   pick;

  function automatic logic [CH_W-1:0] lowest_set(input logic [NUM_CH-1:0] v);
    logic [CH_W-1:0] r;
    r = '0;
    for (int i = NUM_CH - 1; i >= 0; i--) begin
      if (v[i]) r = CH_W'(i);
    end
    return r;
  endfunction

  // selected inputs strictly above the last converted one
  for (genvar g = 0; g < NUM_CH; g++) begin : g_above
    assign above[g] = mask_i[g] && (g > int'(chan_q));
  end

  always_comb begin
    take      = start_i && !busy_q && (|mask_i);
    any_above = |above;
    pick      = any_above ? lowest_set(above) : lowest_set(mask_i);
    chan_d    = pick;
    busy_d    = busy_q;
    if (take)                busy_d = 1'b1;
    else if (busy_q && done_i) busy_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      chan_q <= CH_W'(NUM_CH - 1);
    end else begin
      busy_q <= busy_d;
      if (take) chan_q <= chan_d;
    end
  end

  assign busy_o = busy_q;
  assign chan_o = chan_q;

  assert_pick_in_mask_R4: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> (((($past(mask_i)) >> chan_q) & NUM_CH'(1)) != '0));

  assert_ascend_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (take && any_above) |=> (busy_q && chan_q > $past(chan_q)));

  assert_wrap_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !any_above) |=> (chan_q <= $past(chan_q)));

  assert_empty_mask_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_q && mask_i == '0) |=> !busy_q);

  assert_hold_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !done_i) |=> (busy_q && $stable(chan_q)));

  assert_done_ends_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && done_i) |=> !busy_q);
endmodule

// File: rtl/adc_cfg_stat_pin.sv
module adc_cfg_stat_pin
  import adc_cfg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  pin_mode_e         mode_i,
  input  logic              pol_hi_i,
  input  logic              alert_on_i,
  input  logic              busy_i,
  input  logic              evt_i,
  input  logic [CH_W-1:0]   chan_i,
  input  logic              clr_i,
  output logic [NUM_CH-1:0] status_o,
  output logic              pin_o
);
  logic [NUM_CH-1:0] status_q, status_d;
  logic              upd_en;
  logic              active;

  always_comb begin
    upd_en   = clr_i || (evt_i && alert_on_i);
    status_d = clr_i ? '0 : (status_q | (NUM_CH'(1) << chan_i));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      status_q <= '0;
    else if (upd_en) status_q <= status_d;
  end

  always_comb begin
    unique case (mode_i)
      PIN_BUSY:  active = busy_i;
      PIN_ALERT: active = |status_q;
      default:   active = 1'b0;
    endcase
    pin_o = pol_hi_i ? active : !active;
  end

  assign status_o = status_q;

  assert_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_i |=> ((status_q & $past(status_q)) == $past(status_q)));

  assert_clear_all_R11: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (status_q == '0));

  assert_ignored_evt_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (!alert_on_i && !clr_i) |=> $stable(status_q));

  assert_silent_pin_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == PIN_OFF) |-> (pin_o != pol_hi_i));

  assert_busy_pin_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == PIN_BUSY && busy_i) |-> (pin_o == pol_hi_i));
endmodule

// File: rtl/adc_cfg_seq.sv
module adc_cfg_seq
  import adc_cfg_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_wr,
  input  logic             bus_rd,
  input  logic [CFG_W-1:0] bus_wdata,
  output logic [CFG_W-1:0] bus_rdata,
  input  logic             conv_start,
  input  logic             conv_done,
  input  logic             alert_evt,
  output logic             conv_busy,
  output logic [CH_W-1:0]  conv_chan,
  output logic [NUM_CH-1:0] alert_status,
  output logic             filt_en,
  output logic             stat_pin
);
  logic      rst_n_int;
  cfg_t      cfg;
  logic      clr;
  pin_mode_e pin_mode;

  adc_cfg_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n_async(rst_n),
    .rst_n_sync (rst_n_int)
  );

  adc_cfg_reg u_reg (
    .clk    (clk),
    .rst_n  (rst_n_int),
    .wr_en  (bus_wr),
    .rd_en  (bus_rd),
    .wdata  (bus_wdata),
    .cfg_o  (cfg),
    .rdata_o(bus_rdata),
    .clr_o  (clr)
  );

  adc_cfg_chan_seq u_seq (
    .clk    (clk),
    .rst_n  (rst_n_int),
    .start_i(conv_start),
    .done_i (conv_done),
    .mask_i (cfg.chan_en),
    .busy_o (conv_busy),
    .chan_o (conv_chan)
  );

  assign pin_mode = pin_mode_e'({cfg.alert_on, cfg.role_sel});

  adc_cfg_stat_pin u_pin (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .mode_i    (pin_mode),
    .pol_hi_i  (cfg.pol_hi),
    .alert_on_i(cfg.alert_on),
    .busy_i    (conv_busy),
    .evt_i     (alert_evt),
    .chan_i    (conv_chan),
    .clr_i     (clr),
    .status_o  (alert_status),
    .pin_o     (stat_pin)
  );

  assign filt_en = cfg.filt_on;

  assert_filter_follows_R3: assert property (@(posedge clk) disable iff (!rst_n_int)
    bus_wr |=> (filt_en == $past(bus_wdata[3])));
endmodule

// File: tb/adc_cfg_seq_tb_top.sv
`timescale 1ns/1ps
module adc_cfg_seq_tb_top;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       bus_wr, bus_rd, conv_start, conv_done, alert_evt;
  logic [7:0] bus_wdata;
  logic [7:0] bus_rdata;
  logic       conv_busy, filt_en, stat_pin;
  logic [1:0] conv_chan;
  logic [3:0] alert_status;

  int total = 0;
  int bad   = 0;
  bit finished = 0;

  logic [7:0] m_cfg, m_rd;
  logic       m_busy;
  logic [1:0] m_chan;
  logic [3:0] m_stat;

  always #2 clk = ~clk;

  adc_cfg_seq dut_i (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .conv_start(conv_start),
    .conv_done(conv_done), .alert_evt(alert_evt), .conv_busy(conv_busy),
    .conv_chan(conv_chan), .alert_status(alert_status), .filt_en(filt_en),
    .stat_pin(stat_pin)
  );

  function automatic logic [1:0] nxt_chan(input logic [3:0] m, input logic [1:0] last);
    for (int k = 1; k <= 4; k++) begin
      logic [1:0] c;
      c = last + 2'(k);
      if (m[c]) return c;
    end
    return last;
  endfunction

  function automatic logic exp_pin(input logic [7:0] c, input logic b, input logic [3:0] s);
    logic act;
    case (c[2:1])
      2'b01:   act = b;
      2'b10:   act = |s;
      default: act = 1'b0;
    endcase
    return c[0] ? act : !act;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic compare_all();
    string ptag;
    ptag = (m_cfg[2:1] == 2'b01) ? "R8" : (m_cfg[2:1] == 2'b10) ? "R9" : "R10";
    chk(conv_busy == m_busy, "R7 busy", conv_busy, m_busy);
    chk(conv_chan == m_chan, "R4 chan", conv_chan, m_chan);
    chk(alert_status == m_stat, "R9 status", alert_status, m_stat);
    chk(bus_rdata == m_rd, "R2 rdata", bus_rdata, m_rd);
    chk(filt_en == m_cfg[3], "R3 filter", filt_en, m_cfg[3]);
    chk(stat_pin == exp_pin(m_cfg, m_busy, m_stat), {ptag, " pin"}, stat_pin,
        exp_pin(m_cfg, m_busy, m_stat));
  endtask

  task automatic step(input logic wr, input logic rd, input logic [7:0] wd,
                      input logic st, input logic dn, input logic ev);
    logic clr;
    bus_wr = wr; bus_rd = rd; bus_wdata = wd;
    conv_start = st; conv_done = dn; alert_evt = ev;
    clr = wr && (wd[2:1] == 2'b11);
    if (rd) m_rd = m_cfg;
    if (clr) m_stat = 4'h0;
    else if (ev && m_cfg[2]) m_stat = m_stat | (4'h1 << m_chan);
    if (m_busy) begin
      if (dn) m_busy = 1'b0;
    end else if (st && m_cfg[7:4] != 4'h0) begin
      m_chan = nxt_chan(m_cfg[7:4], m_chan);
      m_busy = 1'b1;
    end
    if (wr) m_cfg = clr ? {wd[7:3], 2'b10, wd[0]} : wd;
    @(negedge clk);
    compare_all();
  endtask

  initial begin
    #(200000 * 4);
    if (!finished) begin
      bad++;
      total++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240607));
    rst_n = 1'b0;
    bus_wr = 0; bus_rd = 0; bus_wdata = 0; conv_start = 0; conv_done = 0; alert_evt = 0;
    m_cfg = 0; m_rd = 0; m_busy = 0; m_chan = 2'd3; m_stat = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk(conv_busy == 0, "R1 busy", conv_busy, 0);
    chk(conv_chan == 2'd3, "R1 chan", conv_chan, 3);
    chk(alert_status == 0, "R1 status", alert_status, 0);
    chk(bus_rdata == 0, "R1 rdata", bus_rdata, 0);
    chk(filt_en == 0, "R1 filter", filt_en, 0);
    chk(stat_pin == 1, "R1 pin", stat_pin, 1);

    // R6 start with empty mask
    step(0, 0, 8'h00, 1, 0, 0);
    chk(conv_busy == 0, "R6 empty mask start", conv_busy, 0);

    // mask inputs 0 and 2, filter on, busy role, active high
    step(1, 0, 8'h5B, 0, 0, 0);
    chk(filt_en == 1, "R3 filter set", filt_en, 1);
    step(0, 1, 8'h00, 0, 0, 0);
    chk(bus_rdata == 8'h5B, "R2 readback", bus_rdata, 8'h5B);
    step(0, 0, 8'h00, 1, 0, 0);
    chk(conv_busy == 1 && conv_chan == 0, "R4 first pick", conv_chan, 0);
    chk(stat_pin == 1, "R8 busy pin high", stat_pin, 1);
    step(0, 0, 8'h00, 0, 1, 0);
    chk(stat_pin == 0, "R8 idle pin low", stat_pin, 0);
    step(0, 0, 8'h00, 1, 0, 0);
    chk(conv_chan == 2, "R4 next ascending", conv_chan, 2);
    step(0, 0, 8'h00, 0, 1, 0);
    step(0, 0, 8'h00, 1, 0, 0);
    chk(conv_chan == 0, "R5 wrap", conv_chan, 0);
    step(0, 0, 8'h00, 1, 0, 0);
    chk(conv_busy == 1 && conv_chan == 0, "R7 start ignored while busy", conv_chan, 0);
    step(0, 0, 8'h00, 0, 1, 0);
    chk(conv_busy == 0, "R7 done clears", conv_busy, 0);

    // alert role, active low
    step(1, 0, 8'h34, 0, 0, 0);
    step(0, 0, 8'h00, 0, 0, 1);
    chk(alert_status == 4'b0001, "R9 status latch", alert_status, 1);
    chk(stat_pin == 0, "R9 alert pin low", stat_pin, 0);
    step(0, 0, 8'h00, 0, 0, 0);
    chk(alert_status == 4'b0001, "R9 sticky", alert_status, 1);
    step(1, 0, 8'h36, 0, 0, 0);
    chk(alert_status == 0 && stat_pin == 1, "R11 clear", alert_status, 0);
    step(0, 1, 8'h00, 0, 0, 0);
    chk(bus_rdata == 8'h34, "R11 readback", bus_rdata, 8'h34);

    // alert disabled
    step(1, 0, 8'h32, 0, 0, 0);
    step(0, 0, 8'h00, 0, 0, 1);
    chk(alert_status == 0, "R12 event ignored", alert_status, 0);

    // silent pin, both polarities
    step(1, 0, 8'h30, 1, 0, 0);
    chk(stat_pin == 1, "R10 silent low-active", stat_pin, 1);
    step(1, 0, 8'h31, 0, 0, 0);
    chk(stat_pin == 0, "R10 silent high-active", stat_pin, 0);

    // random phase
    for (int n = 0; n < 4000; n++) begin
      logic wr, rd, st, dn, ev;
      logic [7:0] wd;
      wr = ($urandom % 8) == 0;
      rd = ($urandom % 3) == 0;
      st = ($urandom % 3) == 0;
      dn = ($urandom % 4) == 0;
      ev = ($urandom % 6) == 0;
      wd = 8'($urandom);
      step(wr, rd, wd, st, dn, ev);
    end

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule